// File: doc/BRIEF.md
# Double-Buffered Table-Permuted Bit Interleaver

This block reorders a serial bit stream in fixed-length blocks. Two one-bit-wide storage banks of N entries alternate duties. During one block the incoming bits are stored in arrival order into one bank. At the same moment, the bank filled during the previous block is drained in the order given by a lookup table. That table maps the running position within the block to the entry to be fetched. The two banks trade duties at every block boundary. The trade is made only by swapping which address bus drives which bank: the running position drives the bank being filled, and the table output drives the bank being drained.

The table is a writable memory with a plain load port. It is filled while the input strobe is idle, usually after power-up, and its contents are expected to form a true permutation of 0..N-1. For example, a table whose entry i holds N-1-i makes every block come out reversed in time. The block length N is a parameter. The full-size configuration uses N = 65536 with 16-bit addresses. The default is kept smaller so that default elaboration stays light.

Top module: `perm_pingpong_ilv`

## Requirements
- R1: After reset `out_valid` and `out_sof` are low, and the block position is 0.
- R2: No `out_valid` is produced for any strobe of the first block after reset, because the drained bank then holds no data.
- R3: From the second block on, the j-th strobe of a block (j counted from 0) produces `out_valid` high exactly one clock cycle later. `out_bit` then equals the bit that arrived at position table[j] of the previous block.
- R4: With the reversal table (entry i = N-1-i), each block is emitted as the previous block in exactly reversed order.
- R5: The block position advances only on cycles with `in_valid` high. Idle cycles between strobes do not shift the ordering, and `out_valid` stays low one cycle after an idle cycle.
- R6: On the strobe at position N-1 the position wraps to 0 and the bank duties swap. Back-to-back strobes across the boundary lose and duplicate no bit.
- R7: `out_sof` is high together with `out_valid` exactly for the output produced by the position-0 strobe of a block.
- R8: A write with `tbl_we` high stores `tbl_data` at entry `tbl_addr`. It is allowed only in cycles without `in_valid`, and it takes effect for every later strobe.
- R9: A reset during a stream discards both banks' contents and restarts at R2 behaviour. Table contents survive the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input bit strobe |
| in_bit | input | 1 | Serial input bit |
| tbl_we | input | 1 | Permutation table write enable |
| tbl_addr | input | AW | Table entry to write |
| tbl_data | input | AW | Permuted index to store |
| out_valid | output | 1 | Output bit strobe |
| out_bit | output | 1 | Serial interleaved output bit |
| out_sof | output | 1 | First output bit of a block |

## Verification
Two things can happen in the same clock edge. The last strobe of a block writes position N-1 into the filling bank and reads the final permuted entry of the draining bank, and in that same edge the duties swap and the position wraps. The bench provokes this by holding `in_valid` high continuously across several block boundaries, and also by placing idle gaps right before and after the boundary. A scoreboard predicts each output from a bench-side model of both blocks and the table. It judges the bit value, the start-of-block flag and the exact cycle of every output, so a bit from the wrong bank, a swap one strobe early or late, or an extra or missing output is each flagged.

// File: rtl/perm_ilv_pkg.sv
package perm_ilv_pkg;
    typedef enum logic {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } bank_e;

    function automatic bank_e other_bank(input bank_e b);
        return (b == BANK_A) ? BANK_B : BANK_A;
    endfunction
endpackage

// File: rtl/ilv_seq_ctr.sv
module ilv_seq_ctr
    import perm_ilv_pkg::*;
#(
    parameter int N  = 1024,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [AW-1:0] seq,
    output bank_e         fill_bank,
    output logic          primed
);
    localparam logic [AW-1:0] LAST = AW'(N - 1);

    typedef struct packed {
        logic [AW-1:0] seq;
        bank_e         bank;
        logic          primed;
    } ctr_t;

    ctr_t ctr_d, ctr_q;
    logic wrap;

    always_comb begin
        ctr_d = ctr_q;
        wrap  = step && (ctr_q.seq == LAST);
        if (step) begin
            ctr_d.seq = wrap ? '0 : ctr_q.seq + 1'b1;
        end
        if (wrap) begin
            ctr_d.bank   = other_bank(ctr_q.bank);
            ctr_d.primed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q <= '{seq: '0, bank: BANK_A, primed: 1'b0};
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign seq       = ctr_q.seq;
    assign fill_bank = ctr_q.bank;
    assign primed    = ctr_q.primed;

    // R6
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && seq == LAST) |=> (seq == '0));
    // R6
    bank_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && seq == LAST) |=> (fill_bank != $past(fill_bank)));
    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> ($stable(seq) && $stable(fill_bank)));
endmodule

// File: rtl/ilv_perm_tbl.sv
module ilv_perm_tbl #(
    parameter int N  = 1024,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [AW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [AW-1:0] rdata
);
    logic [AW-1:0] mem_q [N];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/ilv_bit_bank.sv
module ilv_bit_bank #(
    parameter int N  = 1024,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic          wdata,
    output logic          rdata
);
    logic [N-1:0] mem_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/perm_pingpong_ilv.sv
module perm_pingpong_ilv
    import perm_ilv_pkg::*;
#(
    parameter int N  = 1024,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_bit,
    input  logic          tbl_we,
    input  logic [AW-1:0] tbl_addr,
    input  logic [AW-1:0] tbl_data,
    output logic          out_valid,
    output logic          out_bit,
    output logic          out_sof
);
    localparam int NBANK = 2;

    typedef struct packed {
        logic valid;
        logic bit_v;
        logic sof;
    } out_t;

    out_t out_d, out_q;

    logic [AW-1:0] seq;
    logic [AW-1:0] perm_idx;
    bank_e         fill_bank;
    logic          primed;
    logic [NBANK-1:0] bank_rd;
    logic          drain_bit;

    ilv_seq_ctr #(.N(N), .AW(AW)) ctr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (in_valid),
        .seq       (seq),
        .fill_bank (fill_bank),
        .primed    (primed)
    );

    ilv_perm_tbl #(.N(N), .AW(AW)) tbl_i (
        .clk   (clk),
        .we    (tbl_we),
        .waddr (tbl_addr),
        .wdata (tbl_data),
        .raddr (seq),
        .rdata (perm_idx)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic          is_fill;
        logic [AW-1:0] addr;
        assign is_fill = (fill_bank == bank_e'(b));
        assign addr    = is_fill ? seq : perm_idx;

        ilv_bit_bank #(.N(N), .AW(AW)) bank_i (
            .clk   (clk),
            .we    (in_valid && is_fill),
            .addr  (addr),
            .wdata (in_bit),
            .rdata (bank_rd[b])
        );
    end

    assign drain_bit = bank_rd[other_bank(fill_bank)];

    always_comb begin
        out_d       = out_q;
        out_d.valid = in_valid && primed;
        out_d.sof   = in_valid && primed && (seq == '0);
        if (in_valid && primed) begin
            out_d.bit_v = drain_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid = out_q.valid;
    assign out_bit   = out_q.bit_v;
    assign out_sof   = out_q.sof;

    // R8
    tbl_load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |-> !in_valid);
    // R3
    out_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
    // R7
    sof_in_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);
    // R5
    idle_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
endmodule

// File: tb/perm_pingpong_ilv_tb_top.sv
module perm_pingpong_ilv_tb_top;
    localparam int N  = 16;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_bit = 1'b0;
    logic          tbl_we = 1'b0;
    logic [AW-1:0] tbl_addr = '0;
    logic [AW-1:0] tbl_data = '0;
    logic          out_valid;
    logic          out_bit;
    logic          out_sof;

    always #2 clk = ~clk;

    perm_pingpong_ilv #(.N(N), .AW(AW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_bit    (in_bit),
        .tbl_we    (tbl_we),
        .tbl_addr  (tbl_addr),
        .tbl_data  (tbl_data),
        .out_valid (out_valid),
        .out_bit   (out_bit),
        .out_sof   (out_sof)
    );

    typedef struct {
        logic b;
        logic s;
        int   c;
    } exp_t;

    exp_t  expq[$];
    int    checks = 0;
    int    failures = 0;
    int    cyc = 0;
    bit    done = 0;
    string req = "R3";

    int   tm   [N];
    logic cur  [N];
    logic prev [N];
    int   idx = 0;
    bit   primed = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string r, input bit ok, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d cycle=%0d", r, act, expv, cyc);
        end
    endtask

    // driver: one strobe per cycle, expected result pushed to the scoreboard
    task automatic strobe(input logic b);
        exp_t e;
        in_valid = 1'b1;
        in_bit   = b;
        if (primed) begin
            e.b = prev[tm[idx]];
            e.s = (idx == 0);
            e.c = cyc + 1;
            expq.push_back(e);
        end
        cur[idx] = b;
        idx++;
        if (idx == N) begin
            for (int i = 0; i < N; i++) prev[i] = cur[i];
            idx = 0;
            primed = 1;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic load_entry(input int a, input int d);
        tbl_we   = 1'b1;
        tbl_addr = AW'(a);
        tbl_data = AW'(d);
        tm[a]    = d;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        expq.delete();
        idx = 0;
        primed = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // monitor: pops and compares as the design produces results
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (expq.size() == 0) begin
                    check((primed || idx > 0) ? "R2" : "R5", 1'b0, 1, 0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check(req, e.c == cyc, cyc, e.c);
                    check(req, out_bit == e.b, int'(out_bit), int'(e.b));
                    check("R7", out_sof == e.s, int'(out_sof), int'(e.s));
                end
            end else if (expq.size() > 0 && expq[0].c == cyc) begin
                exp_t e;
                e = expq.pop_front();
                check(req, 1'b0, 0, 1);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1", out_valid == 1'b0, int'(out_valid), 0);
        check("R1", out_sof == 1'b0, int'(out_sof), 0);
        // R8: reversal table loaded while idle (reset still held is fine)
        for (int i = 0; i < N; i++) load_entry(i, N - 1 - i);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", out_valid == 1'b0, int'(out_valid), 0);

        // R2: first block gives no output
        req = "R2";
        for (int i = 0; i < N; i++) strobe(logic'((i * 7 + 1) % 3 == 0));
        // R4 / R6: continuous strobes across several boundaries
        req = "R4";
        for (int k = 0; k < 3; k++)
            for (int i = 0; i < N; i++) strobe(logic'(((i + k) % 5) < 2));
        // R5: gaps, placed around a boundary too
        req = "R5";
        for (int i = 0; i < N; i++) begin
            strobe(logic'(i[0] ^ i[2]));
            if (i % 3 == 0 || i == N - 1) idle(2);
        end
        for (int i = 0; i < N; i++) begin
            if (i == 0) idle(3);
            strobe(logic'(i < 5));
        end
        idle(3);
        // R8: new table between blocks (position 0, idle), stride permutation
        req = "R8";
        for (int i = 0; i < N; i++) load_entry(i, (i * 5 + 3) % N);
        for (int k = 0; k < 2; k++)
            for (int i = 0; i < N; i++) strobe(logic'(((i * 3 + k) % 7) > 3));
        // R6: back-to-back boundary with stride table
        req = "R6";
        for (int i = 0; i < N; i++) strobe(logic'(i % 2 == 1));
        idle(3);
        // R9: reset mid-block, stream restarts empty, table survives
        for (int i = 0; i < 5; i++) strobe(1'b1);
        idle(1);
        do_reset();
        @(negedge clk);
        check("R9", out_valid == 1'b0, int'(out_valid), 0);
        req = "R9";
        for (int k = 0; k < 2; k++)
            for (int i = 0; i < N; i++) strobe(logic'(((i ^ k) % 4) == 1));
        idle(4);
        check("R3", expq.size() == 0, expq.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule